// File: doc/BRIEF.md
# Three-Digit Numeric Display Command Port

This block lets a host drive a three-digit, seven-segment numeric display (tempo values up to 999) over a byte-wide parallel port. The host puts a command byte on the data lines and pulls an active-low strobe. The block synchronises the strobe and accepts the byte on its falling edge. It holds busy high while it works, then pulses an active-low acknowledge for a fixed number of clocks.

Each command byte carries two fields. The low two bits choose which digit to write. The next four bits give the value that digit should show. One select code is kept back as an error marker, and it changes no digit. Out-of-range values show a dash and raise a sticky flag. Each digit register drives its own segment output, active-high, with bit 6 as segment g down to bit 0 as segment a.

Top module: `tempo_disp_port`

## Requirements
- R1: After reset all three segment outputs are 0 (blank), sel_err and val_err are low, busy is low and ack_n is high.
- R2: Command bits 1:0 choose the digit: 00 writes seg_d0, 01 writes seg_d1, 10 writes seg_d2. The other two digits keep their contents.
- R3: Command bits 5:2 give the value. Values 0..9 show the patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex, gfedcba).
- R4: Command bits 7:6 have no effect on any output.
- R5: Select code 11 changes no digit and sets sel_err. It leaves val_err unchanged, whatever the value field holds.
- R6: sel_err stays high until reset or until the next command with a select code other than 11, which clears it.
- R7: A value of 10..15 shows the dash pattern 40 and sets val_err. val_err stays high until reset.
- R8: The strobe passes through a two-stage synchroniser, and the byte is accepted on the strobe's falling edge. busy rises within four clocks of the strobe falling. busy then stays high until the acknowledge has ended and the strobe has been seen high again.
- R9: Every accepted byte gives exactly one acknowledge pulse. ack_n stays low for exactly ACK_LEN clocks, and only while busy is high.
- R10: The segment outputs change only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_n | input | 1 | Active-low host strobe, asynchronous to clk |
| pdata | input | 8 | Command byte; host holds it stable until the acknowledge |
| busy | output | 1 | High from byte capture until the handshake completes |
| ack_n | output | 1 | Active-low acknowledge pulse, ACK_LEN clocks long |
| seg_d0 | output | 7 | Segment pattern of digit 0 (gfedcba, active-high) |
| seg_d1 | output | 7 | Segment pattern of digit 1 |
| seg_d2 | output | 7 | Segment pattern of digit 2 |
| sel_err | output | 1 | Select code 11 received; cleared by the next valid write |
| val_err | output | 1 | Sticky flag for a value above 9 |

## Verification
The bench builds the block with ACK_LEN set to 3. A short acknowledge keeps each handshake to a few dozen clocks, so the bench can afford many of them. Each run writes all ten digit values and all six out-of-range values, uses every select code, and sets the unused upper bits. It measures the exact width of every acknowledge pulse. It also resets the block in mid-run, which shows that the sticky value flag clears only on reset.

// File: rtl/tempo_disp_port.sv
module tempo_disp_port #(
  parameter int ACK_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_n,
  input  logic [7:0] pdata,
  output logic       busy,
  output logic       ack_n,
  output logic [6:0] seg_d0,
  output logic [6:0] seg_d1,
  output logic [6:0] seg_d2,
  output logic       sel_err,
  output logic       val_err
);
  localparam int CW = $clog2(ACK_LEN + 1);

  typedef enum logic [1:0] {IDLE, LOAD, ACKP, DRAIN} st_t;

  st_t         st;
  logic [2:0]  stb_q;
  logic [5:0]  cmd;
  logic [CW-1:0] cnt;
  logic [3:0]  v0, v1, v2;
  logic [2:0]  lit;

  wire       stb_fall = stb_q[2] & ~stb_q[1];
  wire [1:0] sel      = cmd[1:0];
  wire [3:0] val      = cmd[5:2];

  function automatic logic [6:0] enc(input logic on, input logic [3:0] v);
    if (!on) return 7'h00;
    case (v)
      4'd0: return 7'h3F;
      4'd1: return 7'h06;
      4'd2: return 7'h5B;
      4'd3: return 7'h4F;
      4'd4: return 7'h66;
      4'd5: return 7'h6D;
      4'd6: return 7'h7D;
      4'd7: return 7'h07;
      4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h40;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stb_q <= 3'b111;
    else        stb_q <= {stb_q[1:0], strobe_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cmd     <= '0;
      cnt     <= '0;
      v0      <= '0;
      v1      <= '0;
      v2      <= '0;
      lit     <= '0;
      sel_err <= 1'b0;
      val_err <= 1'b0;
    end else begin
      case (st)
        IDLE: if (stb_fall) begin
          cmd <= pdata[5:0];
          st  <= LOAD;
        end
        LOAD: begin
          if (sel != 2'b11) begin
            case (sel)
              2'b00:   v0 <= val;
              2'b01:   v1 <= val;
              default: v2 <= val;
            endcase
            lit[sel] <= 1'b1;
            sel_err  <= 1'b0;
            if (val > 4'd9) val_err <= 1'b1;
          end else begin
            sel_err <= 1'b1;
          end
          cnt <= CW'(ACK_LEN);
          st  <= ACKP;
        end
        ACKP: if (cnt == CW'(1)) st <= DRAIN;
              else cnt <= cnt - CW'(1);
        DRAIN: if (stb_q[1]) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assign busy   = (st != IDLE);
  assign ack_n  = (st != ACKP);
  assign seg_d0 = enc(lit[0], v0);
  assign seg_d1 = enc(lit[1], v1);
  assign seg_d2 = enc(lit[2], v2);
endmodule

// File: rtl/tempo_disp_port_chk.sv
module tempo_disp_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       ack_n,
  input logic [6:0] seg_d0,
  input logic [6:0] seg_d1,
  input logic [6:0] seg_d2,
  input logic       sel_err,
  input logic       val_err
);
  assert_ack_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> busy);

  assert_ack_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ack_n);

  assert_segs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable({seg_d0, seg_d1, seg_d2}));

  assert_valerr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    val_err |=> val_err);

  assert_selerr_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_err) |-> busy);

  assert_selerr_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_err) |-> busy);
endmodule

bind tempo_disp_port tempo_disp_port_chk u_chk (.*);

// File: tb/tempo_disp_port_test.sv
module tempo_disp_port_test;
  localparam int ACK_LEN = 3;

  typedef struct {
    logic [6:0] s0, s1, s2;
    logic       se, ve;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe_n = 1'b1;
  logic [7:0] pdata = '0;
  logic       busy, ack_n, sel_err, val_err;
  logic [6:0] seg_d0, seg_d1, seg_d2;

  int   errors = 0;
  int   checks = 0;
  exp_t sb[$];

  logic [3:0] m_val [3];
  logic       m_lit [3];
  logic       m_se, m_ve;

  always #4 clk = ~clk;

  tempo_disp_port #(.ACK_LEN(ACK_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .pdata(pdata),
    .busy(busy), .ack_n(ack_n), .seg_d0(seg_d0), .seg_d1(seg_d1),
    .seg_d2(seg_d2), .sel_err(sel_err), .val_err(val_err));

  function automatic logic [6:0] pat(input logic on, input logic [3:0] v);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    if (!on) return 7'h00;
    if (v > 4'd9) return 7'h40;
    return t[v];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin m_val[i] = '0; m_lit[i] = 1'b0; end
    m_se = 1'b0;
    m_ve = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input string tag);
    exp_t e;
    int   n;
    int   w;
    if (b[1:0] != 2'b11) begin
      m_val[b[1:0]] = b[5:2];
      m_lit[b[1:0]] = 1'b1;
      m_se = 1'b0;
      if (b[5:2] > 4'd9) m_ve = 1'b1;
    end else begin
      m_se = 1'b1;
    end
    e.s0 = pat(m_lit[0], m_val[0]);
    e.s1 = pat(m_lit[1], m_val[1]);
    e.s2 = pat(m_lit[2], m_val[2]);
    e.se = m_se;
    e.ve = m_ve;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk) pdata = b;
    @(negedge clk) strobe_n = 1'b0;
    w = 0;
    while (!busy && w < 10) begin @(negedge clk); w++; end
    check({"R8 busy within 4 clocks ", tag}, int'(w <= 4), 1);
    while (ack_n) @(negedge clk);
    n = 0;
    while (!ack_n) begin n++; @(negedge clk); end
    check({"R9 ack width ", tag}, n, ACK_LEN);
    check({"R8 busy held after ack ", tag}, busy, 1);
    strobe_n = 1'b1;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  logic busy_q = 1'b0;
  always @(negedge clk) begin
    if (busy_q && !busy) begin
      if (sb.size() == 0) begin
        check("scoreboard empty", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({"R2/R3 seg_d0 ", e.tag}, seg_d0, e.s0);
        check({"R2/R3 seg_d1 ", e.tag}, seg_d1, e.s1);
        check({"R2/R3 seg_d2 ", e.tag}, seg_d2, e.s2);
        check({"R5/R6 sel_err ", e.tag}, sel_err, e.se);
        check({"R7 val_err ", e.tag}, val_err, e.ve);
      end
    end
    busy_q = busy;
  end

  task automatic reset_check();
    @(negedge clk);
    check("R1 seg_d0", seg_d0, 0);
    check("R1 seg_d1", seg_d1, 0);
    check("R1 seg_d2", seg_d2, 0);
    check("R1 flags", {sel_err, val_err}, 0);
    check("R1 busy/ack_n", {busy, ack_n}, 2'b01);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reset_check();

    send(8'h04, "R2 d0=1");
    send(8'h09, "R2 d1=2");
    send(8'h26, "R2 d2=9");
    for (int v = 0; v < 10; v++)
      send(8'((v << 2) | (v % 3)), "R3 value sweep");
    send(8'hDD, "R4 upper bits set d1=7");
    send(8'h80 | 8'h10, "R4 upper bit d0=4");
    send(8'h17, "R5 sel 11 value 5");
    send(8'h3F, "R5 sel 11 value 15 no val_err");
    send(8'h0A, "R6 valid write clears sel_err");
    send(8'h32, "R7 value 12 dash on d2");
    for (int v = 10; v < 16; v++)
      send(8'((v << 2) | (v % 3)), "R7 high values");
    send(8'h20, "R7 val_err stays after valid write");
    send(8'h1B, "R5 sel_err again");

    @(negedge clk) rst_n = 1'b0;
    model_reset();
    @(negedge clk) rst_n = 1'b1;
    reset_check();
    send(8'h25, "R1 post-reset write d1=9");

    repeat (5) @(negedge clk);
    check("scoreboard drained", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule